// File: doc/BRIEF.md
# I2C Register-File Slave with Persistent Pointer

This block is an I2C target that answers on one fixed 7-bit bus address and gives a bus master read and write access to a 64-byte register file. The SCL and SDA wires are oversampled by a fast system clock. SDA is driven open-drain: the block only ever asserts an enable that pulls the line low.

A write transfer carries a pointer byte first. Any bytes after it land in the register file at that pointer. A read transfer streams bytes out from wherever the pointer currently rests. The pointer survives between transfers, so a master can set it once and then issue plain reads. It can also combine a pointer write and a read through a repeated START.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block answers only to the address 7'b1101000 sent MSB first, followed by a direction bit (0 = write, 1 = read). When the address matches, it pulls SDA low during the ninth clock.
- R2: When the address does not match, the block sends no acknowledge. It then neither drives SDA nor changes any register until the next START.
- R3: In a write, the first byte after the address loads the pointer from its low 6 bits. Every later byte is stored at the pointer. Each of these bytes is acknowledged.
- R4: In a read, bytes are sent MSB first, starting at the register the pointer selects. SDA is driven low for 0 bits and released for 1 bits.
- R5: The pointer keeps its value across transfers. A read that is not preceded by a pointer write starts at the stored pointer.
- R6: The pointer advances by one after every byte stored or sent, and it wraps from 63 to 0.
- R7: A master not-acknowledge (SDA high in the ninth clock) ends a read. The block releases SDA and sends nothing more until the next START.
- R8: A repeated START while the bus is busy starts a new address phase without an intervening STOP.
- R9: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) leave SDA released. The block changes its SDA drive only while SCL is low.
- R10: After reset, every register holds 0, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock wire as received |
| sdaIn | input | 1 | Bus data wire as received |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The pointer is internal state, so a wrong pointer first shows up as a wrong data byte. This happens on the very next byte read back, including the first byte of a later read that has no pointer write. A control sequence that is out of step shows up within one bit time. It appears either as a missing or misplaced acknowledge in the ninth clock, or as SDA being driven when the block should be idle. An example of the second case is the byte that follows a not-acknowledge or a foreign address.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  // Strobes from control into datapath, at most one data action per cycle
  typedef struct packed {
    logic rxShift;
    logic ptrLoad;
    logic memWrite;
    logic txLoad;
    logic txShift;
    logic ackDrive;
    logic sdaFree;
  } dpStrb_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_ACK_OUT,
    S_SEND,
    S_ACK_IN
  } ctrlState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } byteKind_t;
endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[STAGES-1];
  assign sdaS    = sdaPipe[STAGES-1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic [PTR_W-1:0]  ptr,
  output logic              sdaOe
);
  logic [BYTE_W-1:0] regFile [DEPTH];
  logic [BYTE_W-1:0] txReg;
  logic [PTR_W-1:0]  ptrNext;

  assign ptrNext = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
      rxByte <= '0;
      txReg  <= '0;
      ptr    <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.ptrLoad) ptr <= rxByte[PTR_W-1:0];
      if (strb.memWrite) begin
        regFile[ptr] <= rxByte;
        ptr          <= ptrNext;
      end
      if (strb.txLoad) begin
        txReg <= regFile[ptr];
        sdaOe <= ~regFile[ptr][BYTE_W-1];
        ptr   <= ptrNext;
      end
      if (strb.txShift) begin
        txReg <= txReg << 1;
        sdaOe <= ~txReg[BYTE_W-2];
      end
      if (strb.ackDrive) sdaOe <= 1'b1;
      if (strb.sdaFree)  sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrb_t           strb
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  ctrlState_t state, stateN;
  byteKind_t  kind, kindN;
  logic [3:0] bitCnt, cntN;
  logic       rwBit, rwN;

  always_comb begin
    strb   = '0;
    stateN = state;
    kindN  = kind;
    cntN   = bitCnt;
    rwN    = rwBit;
    if (startEv) begin
      stateN       = S_RECV;
      kindN        = K_ADDR;
      cntN         = '0;
      strb.sdaFree = 1'b1;
    end else if (stopEv) begin
      stateN       = S_IDLE;
      strb.sdaFree = 1'b1;
    end else begin
      case (state)
        S_RECV: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            strb.rxShift = 1'b1;
            cntN         = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            cntN = '0;
            case (kind)
              K_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  rwN           = rxByte[0];
                  strb.ackDrive = 1'b1;
                  stateN        = S_ACK_OUT;
                end else begin
                  stateN = S_IDLE;
                end
              end
              K_PTR: begin
                strb.ptrLoad  = 1'b1;
                strb.ackDrive = 1'b1;
                stateN        = S_ACK_OUT;
              end
              default: begin
                strb.memWrite = 1'b1;
                strb.ackDrive = 1'b1;
                stateN        = S_ACK_OUT;
              end
            endcase
          end
        end
        S_ACK_OUT: begin
          if (sclFall) begin
            cntN = '0;
            if (kind == K_ADDR && rwBit) begin
              strb.txLoad = 1'b1;
              stateN      = S_SEND;
            end else begin
              strb.sdaFree = 1'b1;
              stateN       = S_RECV;
              kindN        = (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        S_SEND: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            cntN = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              strb.sdaFree = 1'b1;
              cntN         = '0;
              stateN       = S_ACK_IN;
            end else begin
              strb.txShift = 1'b1;
            end
          end
        end
        S_ACK_IN: begin
          if (sclRise) begin
            if (sdaS) stateN = S_IDLE;
            else      cntN   = 4'd1;
          end else if (sclFall && bitCnt == 4'd1) begin
            strb.txLoad = 1'b1;
            cntN        = '0;
            stateN      = S_SEND;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kind   <= K_ADDR;
      bitCnt <= '0;
      rwBit  <= 1'b0;
    end else begin
      state  <= stateN;
      kind   <= kindN;
      bitCnt <= cntN;
      rwBit  <= rwN;
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         DEPTH       = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  localparam int PTR_W = $clog2(DEPTH);

  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [BYTE_W-1:0] rxByte;
  logic [PTR_W-1:0]  ptr;
  dpStrb_t           strb;

  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaS), .rxByte(rxByte),
    .strb(strb)
  );

  i2c_reg_dp #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS),
    .rxByte(rxByte), .ptr(ptr), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2c_reg_chk.sv
module i2c_reg_chk #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclS,
  input logic             startEv,
  input logic             stopEv,
  input logic             sdaOe,
  input logic [PTR_W-1:0] ptr,
  input logic             ptrLoad,
  input logic             memWrite,
  input logic             txLoad
);
  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  // R9: the SDA drive only moves while the bus clock is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclS));

  // R9: START leaves SDA released
  a_r9_start_free: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe);

  // R9: STOP leaves SDA released
  a_r9_stop_free: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R6: outside a pointer load the pointer only steps by one with wrap
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    ((ptr != $past(ptr)) && !$past(ptrLoad)) |-> (ptr == stepPtr($past(ptr))));

  // R3: pointer load, store and fetch never coincide
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ptrLoad, memWrite, txLoad}));
endmodule

bind i2c_reg_slave i2c_reg_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startEv(startEv), .stopEv(stopEv),
  .sdaOe(sdaOe), .ptr(ptr), .ptrLoad(strb.ptrLoad), .memWrite(strb.memWrite),
  .txLoad(strb.txLoad)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [6:0] ADDR = 7'b1101000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;

  int testCnt = 0;
  int failCnt = 0;
  logic [7:0] model [64];
  int mPtr = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  i2c_reg_slave u0 (.clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    tick(Q); mSda = 1'b1; tick(Q); mScl = 1'b1; tick(H);
    mSda = 1'b0; tick(H); mScl = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); mSda = 1'b0; tick(Q); mScl = 1'b1; tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic putBit(input logic b);
    tick(Q); mSda = b; tick(Q); mScl = 1'b1; tick(H); mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    tick(Q); mSda = 1'b1; tick(Q); mScl = 1'b1; tick(Q);
    acked = ~sdaLine;
    tick(Q); mScl = 1'b0;
  endtask

  task automatic getByte(input logic nack, output logic [7:0] d);
    tick(Q); mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); mScl = 1'b1; tick(Q); d[i] = sdaLine; tick(Q); mScl = 1'b0; tick(Q);
    end
    putBit(nack);
  endtask

  function automatic int stepP(input int p);
    return (p + 1) % 64;
  endfunction

  // Pointer write then data bytes
  task automatic doWrite(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte({ADDR, 1'b0}, a); check(a, "R1", a, 1);
    sendByte(p, a); check(a, "R3", a, 1);
    mPtr = int'(p[5:0]);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, a); check(a, req, a, 1);
      model[mPtr] = d;
      mPtr = stepP(mPtr);
    end
    busStop();
    check(sdaOe == 1'b0, "R9", sdaOe, 0);
  endtask

  // Read n bytes, optionally setting the pointer through a repeated START
  task automatic doRead(input bit setPtr, input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] d;
    busStart();
    if (setPtr) begin
      sendByte({ADDR, 1'b0}, a); check(a, "R1", a, 1);
      sendByte(p, a); check(a, "R3", a, 1);
      mPtr = int'(p[5:0]);
      busStart();
    end
    sendByte({ADDR, 1'b1}, a); check(a, setPtr ? "R8" : "R1", a, 1);
    for (int k = 0; k < n; k++) begin
      getByte(k == n - 1, d);
      check(d == model[mPtr], req, d, model[mPtr]);
      mPtr = stepP(mPtr);
    end
    busStop();
    check(sdaOe == 1'b0, "R9", sdaOe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'd1307));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    check(sdaOe == 1'b0, "R10", sdaOe, 0);

    // R10: reset contents read from reset pointer 0
    doRead(1'b0, 8'h00, 3, "R10");

    // R3 / R4 / R8: burst write then readback via repeated START
    doWrite(8'd10, 4, "R3");
    doRead(1'b1, 8'd10, 4, "R4");

    // R5: read with no pointer write continues at stored pointer
    doWrite(8'd20, 3, "R3");
    doRead(1'b1, 8'd20, 1, "R4");
    doRead(1'b0, 8'h00, 2, "R5");

    // R6: wrap from 63 to 0
    doWrite(8'd62, 4, "R6");
    doRead(1'b1, 8'd62, 4, "R6");

    // R3: upper pointer bits are dropped (0xC5 selects 5)
    doWrite(8'hC5, 1, "R3");
    doRead(1'b1, 8'h05, 1, "R3");

    // R2: foreign address in write direction, nothing acked or stored
    busStart();
    sendByte(8'h50, a); check(!a, "R2", a, 0);
    sendByte(8'h05, a); check(!a, "R2", a, 0);
    sendByte(8'hEE, a); check(!a, "R2", a, 0);
    busStop();
    doRead(1'b1, 8'h05, 1, "R2");
    // R2: foreign address in read direction, bus stays released
    busStart();
    sendByte({7'b1101001, 1'b1}, a); check(!a, "R2", a, 0);
    getByte(1'b1, d); check(d == 8'hFF, "R2", d, 8'hFF);
    busStop();

    // R7: NACK ends the read, further clocks see a released bus
    doWrite(8'd30, 2, "R3");
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'd30, a);
    busStart();
    sendByte({ADDR, 1'b1}, a); check(a, "R8", a, 1);
    getByte(1'b1, d); check(d == model[30], "R7", d, model[30]);
    check(sdaOe == 1'b0, "R7", sdaOe, 0);
    getByte(1'b1, d); check(d == 8'hFF, "R7", d, 8'hFF);
    busStop();
    mPtr = 31;
    doRead(1'b0, 8'h00, 1, "R7");

    // Random mix of transfers
    for (int it = 0; it < 20; it++) begin
      int op;
      int len;
      logic [7:0] p;
      op  = int'($urandom_range(0, 2));
      len = int'($urandom_range(1, 4));
      p   = 8'($urandom);
      if (op == 0)      doWrite(p, len, "R3");
      else if (op == 1) doRead(1'b1, p, len, "R4");
      else              doRead(1'b0, 8'h00, len, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule